// File: doc/BRIEF.md
# Two-Channel Driver Supply Interlock

This block is the supervisory control logic of a two-channel isolated gate driver. It watches three supply-good flags: one for the control side and one for each of the two output sides. It also takes an active-high enable and one command bit per channel. It produces the two gated drive commands and a registered ready status. A channel is driven high only when four things hold. Its command is high. Enable is high. The control-side supply has been good for a whole start-up interval. Its own output supply has been good for a whole output start-up interval.

Two build-time options set the variant. `SAFE_START` selects the long control-side start-up interval instead of the short one. `CROSS_TRIP` selects the enhanced mode. In that mode an output supply that is not qualified on either side forces both channels low, so the two channels are never left unbalanced. All delays are counted in clock cycles. The supply flags are clean signals that are already synchronous to `clk`. There is no data stream in this block: every pin is plain level control or status, and nothing applies back-pressure.

Top module: `iso_drv_interlock`

## Requirements
- R1: While `vin_good` is low, both `drv_a` and `drv_b` are low from the next clock edge on, whatever `en`, `cmd_a` and `cmd_b` do. A low `en` has no further effect in that state.
- R2: While `en` is low, both drive outputs are low from the next clock edge on.
- R3: After `vin_good` rises, both outputs stay low until `vin_good` has been sampled high on START edges. START is `START_LONG_CYC` when `SAFE_START`=1 and `START_SHORT_CYC` otherwise. On the edge that follows, the outputs may go high.
- R4: After an output supply flag rises, that channel stays low until the flag has been sampled high on `OUT_START_CYC` edges. It may go high on the edge that follows.
- R5: A low `vout_a_good` forces `drv_a` low from the next edge, and a low `vout_b_good` does the same for `drv_b`. With `CROSS_TRIP`=0 the other channel keeps following its command.
- R6: With `CROSS_TRIP`=1, a channel is also held low while the opposite output supply is low or still in its own start-up interval.
- R7: `ready` is a register. It holds the AND of `vin_good`, `vout_a_good` and `vout_b_good` sampled on the previous edge. It has no start-up delay and no sticky state.
- R8: When `en` rises and all supplies are qualified, the outputs follow their commands on the very next edge, with no added delay.
- R9: Raising `en` while a start-up interval is still running does not shorten that interval.
- R10: When all conditions hold, each drive output equals its command sampled on the previous edge.
- R11: While `rst_n` is low, `drv_a`, `drv_b` and `ready` are low and all start-up counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_good | input | 1 | Control-side supply above its lockout threshold |
| vout_a_good | input | 1 | Channel A output supply above its lockout threshold |
| vout_b_good | input | 1 | Channel B output supply above its lockout threshold |
| en | input | 1 | Active-high enable |
| cmd_a | input | 1 | Channel A command |
| cmd_b | input | 1 | Channel B command |
| drv_a | output | 1 | Gated channel A drive command |
| drv_b | output | 1 | Gated channel B drive command |
| ready | output | 1 | All three supplies good, registered |

## Verification
A start-up counter that is off by one shows at a drive pin. The output rises one edge early or one edge late against the START or `OUT_START_CYC` boundary, so the bench samples both sides of each boundary. A qualifier that keeps its state after its supply drops, or a cross-trip path that is missing or wired to the wrong side, shows within one edge: a drive output stays high while the offending flag is low. A `ready` register fed from the wrong source shows as a one-cycle mismatch against the AND of the three flags.

// File: rtl/iso_drv_pkg.sv
package iso_drv_pkg;
  localparam int unsigned NUM_SUP = 3;
  localparam int unsigned NUM_CH  = 2;

  // Supply slot indices; channel c uses slot SUP_OUT0 + c
  localparam int unsigned SUP_CTRL = 0;
  localparam int unsigned SUP_OUT0 = 1;

  function automatic int unsigned peer_slot(input int unsigned ch);
    return SUP_OUT0 + (NUM_CH - 1 - ch);
  endfunction
endpackage

// File: rtl/iso_drv_sup_qual.sv
// Counts consecutive good samples of one supply flag; qualified after DELAY.
module iso_drv_sup_qual #(
  parameter int unsigned DELAY = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good,
  output logic ok
);
  localparam int unsigned CW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!good)        cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ok = good && (cnt == LIMIT);
endmodule

// File: rtl/iso_drv_chan_gate.sv
// One channel's output register with all gating terms.
module iso_drv_chan_gate #(
  parameter bit CROSS_TRIP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_ok,
  input  logic en,
  input  logic own_ok,
  input  logic peer_ok,
  input  logic cmd,
  output logic drv
);
  logic permit;

  generate
    if (CROSS_TRIP) begin : g_cross
      assign permit = ctrl_ok && en && own_ok && peer_ok;
    end else begin : g_indep
      logic unused_peer;
      assign unused_peer = peer_ok;
      assign permit = ctrl_ok && en && own_ok;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv <= 1'b0;
    else        drv <= permit && cmd;
  end
endmodule

// File: rtl/iso_drv_ready_reg.sv
// Registered all-supplies-good status.
module iso_drv_ready_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] good,
  output logic         ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready <= 1'b0;
    else        ready <= &good;
  end
endmodule

// File: rtl/iso_drv_interlock.sv
module iso_drv_interlock
  import iso_drv_pkg::*;
#(
  parameter int unsigned START_SHORT_CYC = 40,
  parameter int unsigned START_LONG_CYC  = 1000,
  parameter int unsigned OUT_START_CYC   = 60,
  parameter bit          SAFE_START      = 1'b0,
  parameter bit          CROSS_TRIP      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vin_good,
  input  logic vout_a_good,
  input  logic vout_b_good,
  input  logic en,
  input  logic cmd_a,
  input  logic cmd_b,
  output logic drv_a,
  output logic drv_b,
  output logic ready
);
  localparam int unsigned CTRL_DLY = SAFE_START ? START_LONG_CYC : START_SHORT_CYC;

  logic [NUM_SUP-1:0] sup_good;
  logic [NUM_SUP-1:0] sup_ok;
  logic [NUM_CH-1:0]  cmd_v;
  logic [NUM_CH-1:0]  drv_v;

  assign sup_good = {vout_b_good, vout_a_good, vin_good};
  assign cmd_v    = {cmd_b, cmd_a};

  for (genvar s = 0; s < NUM_SUP; s++) begin : g_sup
    iso_drv_sup_qual #(
      .DELAY((s == SUP_CTRL) ? CTRL_DLY : OUT_START_CYC)
    ) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .good (sup_good[s]),
      .ok   (sup_ok[s])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    iso_drv_chan_gate #(
      .CROSS_TRIP(CROSS_TRIP)
    ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl_ok(sup_ok[SUP_CTRL]),
      .en     (en),
      .own_ok (sup_ok[SUP_OUT0 + c]),
      .peer_ok(sup_ok[peer_slot(c)]),
      .cmd    (cmd_v[c]),
      .drv    (drv_v[c])
    );
  end

  iso_drv_ready_reg #(.N(NUM_SUP)) u_ready (
    .clk  (clk),
    .rst_n(rst_n),
    .good (sup_good),
    .ready(ready)
  );

  assign drv_a = drv_v[0];
  assign drv_b = drv_v[1];
endmodule

// File: rtl/iso_drv_interlock_chk.sv
module iso_drv_interlock_chk #(
  parameter bit CROSS_TRIP = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic vin_good,
  input logic vout_a_good,
  input logic vout_b_good,
  input logic en,
  input logic cmd_a,
  input logic cmd_b,
  input logic drv_a,
  input logic drv_b,
  input logic ready
);
  a_r1_ctrl_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !vin_good |=> (!drv_a && !drv_b));

  a_r2_enable_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drv_a && !drv_b));

  a_r3_rise_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vin_good) |=> (!drv_a && !drv_b));

  a_r5_own_supply_a: assert property (@(posedge clk) disable iff (!rst_n)
    !vout_a_good |=> !drv_a);

  a_r5_own_supply_b: assert property (@(posedge clk) disable iff (!rst_n)
    !vout_b_good |=> !drv_b);

  a_r6_cross_a: assert property (@(posedge clk) disable iff (!rst_n)
    (CROSS_TRIP && !vout_b_good) |=> !drv_a);

  a_r6_cross_b: assert property (@(posedge clk) disable iff (!rst_n)
    (CROSS_TRIP && !vout_a_good) |=> !drv_b);

  a_r7_ready_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (vin_good && vout_a_good && vout_b_good) |=> ready);

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !(vin_good && vout_a_good && vout_b_good) |=> !ready);

  a_r10_rise_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_a) |-> $past(en && cmd_a && vin_good && vout_a_good));

  a_r10_rise_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_b) |-> $past(en && cmd_b && vin_good && vout_b_good));
endmodule

bind iso_drv_interlock iso_drv_interlock_chk #(.CROSS_TRIP(CROSS_TRIP)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .vin_good   (vin_good),
  .vout_a_good(vout_a_good),
  .vout_b_good(vout_b_good),
  .en         (en),
  .cmd_a      (cmd_a),
  .cmd_b      (cmd_b),
  .drv_a      (drv_a),
  .drv_b      (drv_b),
  .ready      (ready)
);

// File: tb/iso_drv_interlock_tb_top.sv
`timescale 1ns/1ps
module iso_drv_interlock_tb_top;
  localparam int unsigned SHORT_D = 40;
  localparam int unsigned LONG_D  = 1000;
  localparam int unsigned OUT_D   = 60;
  localparam int unsigned SETTLE  = LONG_D + OUT_D + 10;
  localparam int unsigned NROWS   = 12;

  // row: {vin,va,vb,en,ca,cb, exp_a,exp_b (indep), exp_xa,exp_xb (cross), exp_rdy}
  localparam logic [10:0] VEC [NROWS] = '{
    11'b111_1_10_10_10_1,
    11'b111_1_01_01_01_1,
    11'b111_1_11_11_11_1,
    11'b111_1_00_00_00_1,
    11'b111_0_11_00_00_1,
    11'b011_1_11_00_00_0,
    11'b011_0_11_00_00_0,
    11'b101_1_11_01_00_0,
    11'b110_1_11_10_00_0,
    11'b100_1_11_00_00_0,
    11'b000_1_11_00_00_0,
    11'b110_1_10_10_00_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin_good = 1'b0, vout_a_good = 1'b0, vout_b_good = 1'b0;
  logic en = 1'b0, cmd_a = 1'b0, cmd_b = 1'b0;
  logic drv_a, drv_b, ready;
  logic xdrv_a, xdrv_b, xready;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  iso_drv_interlock #(
    .START_SHORT_CYC(SHORT_D), .START_LONG_CYC(LONG_D), .OUT_START_CYC(OUT_D),
    .SAFE_START(1'b0), .CROSS_TRIP(1'b0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .vin_good(vin_good), .vout_a_good(vout_a_good),
    .vout_b_good(vout_b_good), .en(en), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .drv_a(drv_a), .drv_b(drv_b), .ready(ready)
  );

  iso_drv_interlock #(
    .START_SHORT_CYC(SHORT_D), .START_LONG_CYC(LONG_D), .OUT_START_CYC(OUT_D),
    .SAFE_START(1'b1), .CROSS_TRIP(1'b1)
  ) dut_x (
    .clk(clk), .rst_n(rst_n), .vin_good(vin_good), .vout_a_good(vout_a_good),
    .vout_b_good(vout_b_good), .en(en), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .drv_a(xdrv_a), .drv_b(xdrv_b), .ready(xready)
  );

  task automatic step(input int unsigned n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic all_good();
    vin_good = 1'b1; vout_a_good = 1'b1; vout_b_good = 1'b1;
    en = 1'b1; cmd_a = 1'b1; cmd_b = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state with everything requesting drive
    @(negedge clk);
    all_good();
    step(3);
    chk({drv_a, drv_b, ready}, 3'b000, "R11 indep reset");
    chk({xdrv_a, xdrv_b, xready}, 3'b000, "R11 cross reset");
    rst_n = 1'b1;
    step(SETTLE);
    chk({drv_a, drv_b, ready}, 3'b111, "R10 indep qualified");
    chk({xdrv_a, xdrv_b, xready}, 3'b111, "R10 cross qualified");

    // Truth-table walk: R1 R2 R5 R6 R7 R10
    for (int r = 0; r < NROWS; r++) begin
      {vin_good, vout_a_good, vout_b_good, en, cmd_a, cmd_b} = VEC[r][10:5];
      step(1);
      chk({drv_a, drv_b, ready}, {VEC[r][4:3], VEC[r][0]}, $sformatf("R1/R2/R5/R7 indep row %0d", r));
      chk({xdrv_a, xdrv_b, xready}, {VEC[r][2:1], VEC[r][0]}, $sformatf("R6/R7 cross row %0d", r));
      all_good();
      step(SETTLE);
    end

    // R3: control-side start-up boundaries (short and long)
    vin_good = 1'b0;
    step(1);
    vin_good = 1'b1;
    step(SHORT_D);
    chk({drv_a, drv_b, ready}, 3'b001, "R3 short interval still low");
    step(1);
    chk({drv_a, drv_b, ready}, 3'b111, "R3 short interval expired");
    step(LONG_D - SHORT_D - 1);
    chk({xdrv_a, xdrv_b, xready}, 3'b001, "R3 long interval still low");
    step(1);
    chk({xdrv_a, xdrv_b, xready}, 3'b111, "R3 long interval expired");

    // R4 / R5 / R6: output-side start-up boundary
    vout_a_good = 1'b0;
    step(1);
    vout_a_good = 1'b1;
    step(OUT_D);
    chk({drv_a, drv_b, ready}, 3'b011, "R4 R5 channel A waits, B runs");
    chk({xdrv_a, xdrv_b, xready}, 3'b001, "R6 cross holds both during A start");
    step(1);
    chk({drv_a, drv_b, ready}, 3'b111, "R4 channel A resumes");
    chk({xdrv_a, xdrv_b, xready}, 3'b111, "R6 cross both resume");

    // R8: enable stop and immediate restart
    en = 1'b0;
    step(1);
    chk({drv_a, drv_b, xdrv_a}, 3'b000, "R8 enable falls");
    en = 1'b1;
    step(1);
    chk({drv_a, drv_b, xdrv_a}, 3'b111, "R8 enable rises, no delay");

    // R9: enable during start-up does not shorten it
    en = 1'b0; vin_good = 1'b0;
    step(1);
    vin_good = 1'b1;
    step(20);
    en = 1'b1;
    step(SHORT_D - 20);
    chk({drv_a, drv_b, ready}, 3'b001, "R9 interval not shortened");
    step(1);
    chk({drv_a, drv_b, ready}, 3'b111, "R9 outputs after interval");

    // R7: simultaneous flag changes, no sticky state
    vout_a_good = 1'b0; vout_b_good = 1'b0;
    step(1);
    chk({ready, xready, 1'b0}, 3'b000, "R7 ready drops");
    vout_a_good = 1'b1; vout_b_good = 1'b1;
    step(1);
    chk({ready, xready, 1'b0}, 3'b110, "R7 ready recovers next edge");

    // R10: command following with one-edge latency
    step(OUT_D + 2);
    cmd_a = 1'b0;
    step(1);
    chk({drv_a, drv_b, xdrv_a}, 3'b010, "R10 command follows");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule